// File: doc/BRIEF.md
# Auto-Reload Timer PWM Generator

This block is an up-counting timer whose wrap-around drives a pulse-width modulated output. The counter rolls over at its all-ones value and either restarts from a programmable reload value or from zero. The output level flips on the overflow event and when the count equals a programmable compare value. The reload value sets the period and the compare value sets the active time. Both sit near the top of the counter range.

Software programs it through a plain write-strobe register port with a combinational read port. There are four registers: reload, compare, counter and control. The control word holds run, auto-reload, compare enable, output inversion, the trigger selection and a prescaler. A clock-enable input gates all counting. To get an in-phase waveform, software writes the counter to all-ones minus one while the timer is stopped and then sets the run bit. The first overflow then comes two counting ticks later and starts the active phase.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset all four registers read back as zero, and `pwmOut` and `ovfEvt` are low.
- R2: While the run bit is clear, the counter keeps its value and `pwmOut` sits at its inactive level. The inactive level is 0, or 1 when the inversion bit is set.
- R3: While running, with the prescaler off and `clkEn` high, the counter rises by one on each clock. While `clkEn` is low, the counter holds its value.
- R4: When a counting tick finds the counter at all-ones with auto-reload set, the counter takes the reload value. `ovfEvt` is high for exactly that one clock.
- R5: With auto-reload clear, the counter wraps from all-ones to zero.
- R6: In the both-events trigger mode with compare enabled, one period lasts (all-ones − reload + 1) ticks. The active phase lasts (compare − reload + 1) ticks. A start from all-ones minus one enters the active phase after the second tick.
- R7: The inversion bit (control bit 3) turns the whole waveform upside down, including the level while the timer is stopped.
- R8: The trigger field (control bits 5:4) selects the toggling events: 0 means none, 1 means overflow only, 2 means compare only, 3 means both. The compare enable (bit 2) must be set for compare events to count.
- R9: With the prescaler enable (bit 6) set, the counter advances once every 2^(sel+1) enabled clocks, where sel is the 3-bit field in bits 9:7.
- R10: Configurations outside reload ≤ compare < all-ones do not lock the block up. The counter keeps cycling through its reload range. A compare value of all-ones makes both events fall on the same tick, so they cancel.
- R11: The register addresses are 0 for reload, 1 for compare, 2 for counter and 3 for control. Each written value reads back at the same address. The run bit is control bit 0 and auto-reload is bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkEn | input | 1 | Gates counting and prescaling |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 32 | Read data for `rdAddr` (combinational) |
| pwmOut | output | 1 | PWM output pin |
| ovfEvt | output | 1 | One-clock pulse on each counter overflow |

## Verification
The readable counter exposes any slip in the count sequence on the very next clock. An overflow that reloads the wrong value shows as a wrong counter readback one tick after `ovfEvt`. A corrupted output-level register flips the phase of `pwmOut`. That error persists for the rest of the run, so a stretch of sampled waveform compared against the period and duty formulas catches it within one period. Prescaler counting errors appear as a counter value that is off after a known number of enabled clocks. The prescaler cases include the largest division ratio.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  // Register map
  typedef enum logic [1:0] {
    ADDR_LOAD  = 2'd0,
    ADDR_MATCH = 2'd1,
    ADDR_COUNT = 2'd2,
    ADDR_CTRL  = 2'd3
  } reg_addr_e;

  // Trigger selection: bit 0 enables overflow toggles, bit 1 compare toggles
  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_OVF   = 2'd1,
    TRIG_MATCH = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  // Control word layout
  localparam int PSC_SEL_W  = 3;
  localparam int CTL_RUN    = 0;
  localparam int CTL_RELOAD = 1;
  localparam int CTL_CMP    = 2;
  localparam int CTL_INV    = 3;
  localparam int CTL_TRIG   = 4;   // two bits
  localparam int CTL_PSC_EN = 6;
  localparam int CTL_PSC    = 7;   // PSC_SEL_W bits
  localparam int CTRL_W     = CTL_PSC + PSC_SEL_W;

  // Strobes and mode bits from control to datapath
  typedef struct packed {
    logic tick;
    logic cntWr;
    logic autoReload;
    logic cmpEn;
    logic ovfTog;
    logic matchTog;
    logic running;
  } dp_ctrl_t;

endpackage

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clkEn,
  input  logic                     wrEn,
  input  logic [1:0]               wrAddr,
  input  logic [CNT_W-1:0]         wrData,
  output logic [CNT_W-1:0]         loadVal,
  output logic [CNT_W-1:0]         matchVal,
  output logic [CTRL_W-1:0]        ctrlWord,
  output logic                     invert,
  output dp_ctrl_t                 strobe
);

  localparam int PSC_CNT_W = 2 ** PSC_SEL_W;

  logic                 runQ;
  logic                 reloadQ;
  logic                 cmpQ;
  logic                 invQ;
  trig_e                trigQ;
  logic                 pscEnQ;
  logic [PSC_SEL_W-1:0] pscSelQ;
  logic [PSC_CNT_W-1:0] pscCnt;
  logic [PSC_CNT_W:0]   divFull;
  logic [PSC_CNT_W-1:0] pscLimit;
  logic                 pscWrap;
  logic                 prescTick;
  logic                 ctrlWr;

  assign ctrlWr = wrEn && (reg_addr_e'(wrAddr) == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal  <= '0;
      matchVal <= '0;
      runQ     <= 1'b0;
      reloadQ  <= 1'b0;
      cmpQ     <= 1'b0;
      invQ     <= 1'b0;
      trigQ    <= TRIG_NONE;
      pscEnQ   <= 1'b0;
      pscSelQ  <= '0;
    end else if (wrEn) begin
      case (reg_addr_e'(wrAddr))
        ADDR_LOAD:  loadVal  <= wrData;
        ADDR_MATCH: matchVal <= wrData;
        ADDR_CTRL: begin
          runQ    <= wrData[CTL_RUN];
          reloadQ <= wrData[CTL_RELOAD];
          cmpQ    <= wrData[CTL_CMP];
          invQ    <= wrData[CTL_INV];
          trigQ   <= trig_e'(wrData[CTL_TRIG +: 2]);
          pscEnQ  <= wrData[CTL_PSC_EN];
          pscSelQ <= wrData[CTL_PSC +: PSC_SEL_W];
        end
        default: ;
      endcase
    end
  end

  // Divide ratio 2^(sel+1); limit is ratio-1 (wraps to all-ones at the top)
  always_comb begin
    divFull  = (PSC_CNT_W+1)'(1) << ({1'b0, pscSelQ} + 1'b1);
    pscLimit = divFull[PSC_CNT_W-1:0] - 1'b1;
  end

  assign pscWrap   = (pscCnt == pscLimit);
  assign prescTick = pscEnQ ? pscWrap : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (!runQ) begin
      pscCnt <= '0;
    end else if (clkEn) begin
      if (!pscEnQ || pscWrap) pscCnt <= '0;
      else                    pscCnt <= pscCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.tick       = runQ && clkEn && prescTick;
    strobe.cntWr      = wrEn && (reg_addr_e'(wrAddr) == ADDR_COUNT);
    strobe.autoReload = reloadQ;
    strobe.cmpEn      = cmpQ;
    strobe.ovfTog     = trigQ[0];
    strobe.matchTog   = trigQ[1];
    strobe.running    = runQ;
  end

  assign invert   = invQ;
  assign ctrlWord = {pscSelQ, pscEnQ, trigQ, invQ, cmpQ, reloadQ, runQ};

  // R9: every prescaled tick restarts the divider
  p_psc_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && pscEnQ) |=> (pscCnt == '0));

  // R3: a low clock enable freezes the divider while running
  p_clken_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !clkEn) |=> $stable(pscCnt));

  // R2: a write to the control word is the only way to leave the stopped state
  p_stay_stopped_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !ctrlWr) |=> !runQ);

endmodule

// File: rtl/rpt_datapath.sv
module rpt_datapath
  import rpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctrl_t         strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0] count,
  output logic             level,
  output logic             ovfEvt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic atTop;
  logic matchEvt;
  logic toggle;

  assign atTop    = (count == CNT_MAX);
  assign ovfEvt   = strobe.tick && atTop;
  assign matchEvt = strobe.tick && strobe.cmpEn && (count == matchVal);
  // Coinciding events cancel; keeps the line sane when compare sits at the top
  assign toggle   = (ovfEvt && strobe.ovfTog) ^ (matchEvt && strobe.matchTog);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntWr) begin
      count <= wrData;
    end else if (strobe.tick) begin
      if (atTop) count <= strobe.autoReload ? loadVal : '0;
      else       count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                level <= 1'b0;
    else if (!strobe.running) level <= 1'b0;
    else if (toggle)          level <= ~level;
  end

  // R3: ordinary tick increments by one
  p_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !atTop && !strobe.cntWr) |=> (count == $past(count) + 1'b1));

  // R2: no tick and no write leaves the counter untouched
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.cntWr) |=> $stable(count));

  // R4: overflow with auto-reload lands on the reload value
  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvt && strobe.autoReload && !strobe.cntWr) |=> (count == $past(loadVal)));

  // R4: overflow pulse lasts one clock unless the reload value is the top itself
  p_ovf_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvt && (loadVal != CNT_MAX) && !strobe.cntWr) |=> !ovfEvt);

  // R5: overflow without auto-reload lands on zero
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvt && !strobe.autoReload && !strobe.cntWr) |=> (count == '0));

  // R8: with no trigger selected the level never flips while running
  p_no_trig_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.running && !strobe.ovfTog && !strobe.matchTog) |=> (level == $past(level)));

endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
  import rpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             pwmOut,
  output logic             ovfEvt
);

  dp_ctrl_t          strobe;
  logic [CNT_W-1:0]  loadVal;
  logic [CNT_W-1:0]  matchVal;
  logic [CNT_W-1:0]  count;
  logic [CTRL_W-1:0] ctrlWord;
  logic              invert;
  logic              level;

  rpt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .loadVal  (loadVal),
    .matchVal (matchVal),
    .ctrlWord (ctrlWord),
    .invert   (invert),
    .strobe   (strobe)
  );

  rpt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .loadVal  (loadVal),
    .matchVal (matchVal),
    .count    (count),
    .level    (level),
    .ovfEvt   (ovfEvt)
  );

  always_comb begin
    case (reg_addr_e'(rdAddr))
      ADDR_LOAD:  rdData = loadVal;
      ADDR_MATCH: rdData = matchVal;
      ADDR_COUNT: rdData = count;
      default:    rdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlWord};
    endcase
  end

  assign pwmOut = (level && strobe.running) ^ invert;

  // R7: the pin follows the internal level with the selected polarity
  p_polarity_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.running |-> (pwmOut == (level ^ invert)));

endmodule

// File: tb/reload_pwm_timer_bench.sv
module reload_pwm_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOP = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        pwmOut;
  logic        ovfEvt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic samp [1:40];

  reload_pwm_timer u_reload_pwm_timer (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut),
    .ovfEvt(ovfEvt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  function automatic logic [31:0] ctl(input bit run, input bit rel, input bit cmp,
                                      input bit inv, input logic [1:0] trig,
                                      input bit pen, input logic [2:0] sel);
    return {22'd0, sel, pen, trig, inv, cmp, rel, run};
  endfunction

  // Program, preload top-1, start, and sample pwmOut on n negedges
  task automatic runWave(input logic [31:0] ld, input logic [31:0] mt,
                         input logic [31:0] cw, input int n);
    wr(2'd3, cw & ~32'h1);
    wr(2'd0, ld);
    wr(2'd1, mt);
    wr(2'd2, TOP - 1);
    wr(2'd3, cw | 32'h1);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      samp[k] = pwmOut;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register zero", v, 32'd0);
    end
    chk("R1 pwmOut low", {31'd0, pwmOut}, 32'd0);
    chk("R1 ovfEvt low", {31'd0, ovfEvt}, 32'd0);
  endtask

  task automatic t_stopped;
    logic [31:0] v;
    wr(2'd2, 32'h0000_1234);
    repeat (5) @(negedge clk);
    rd(2'd2, v);
    chk("R2 counter holds when stopped", v, 32'h0000_1234);
    chk("R2 idle level low", {31'd0, pwmOut}, 32'd0);
    wr(2'd3, ctl(0, 0, 0, 1, 2'd0, 0, 3'd0));
    chk("R2 idle level follows inversion", {31'd0, pwmOut}, 32'd1);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(2'd3, ctl(1, 0, 0, 0, 2'd0, 0, 3'd0));
    repeat (3) @(negedge clk);
    rd(2'd2, v);
    chk("R3 counts one per clock", v, 32'h0000_1237);
    clkEn = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd2, v);
    chk("R3 clkEn low holds counter", v, 32'h0000_1237);
    clkEn = 1'b1;
    @(negedge clk);
    rd(2'd2, v);
    chk("R3 resumes after clkEn", v, 32'h0000_1238);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FF00);
    wr(2'd2, 32'hFFFF_FFFD);
    wr(2'd3, ctl(1, 1, 0, 0, 2'd0, 0, 3'd0));
    @(negedge clk);
    chk("R4 no overflow before top", {31'd0, ovfEvt}, 32'd0);
    @(negedge clk);
    chk("R4 overflow pulse at top", {31'd0, ovfEvt}, 32'd1);
    @(negedge clk);
    rd(2'd2, v);
    chk("R4 reload value taken", v, 32'hFFFF_FF00);
    chk("R4 overflow pulse one clock", {31'd0, ovfEvt}, 32'd0);
    wr(2'd3, 32'd0);
    wr(2'd2, TOP - 1);
    wr(2'd3, ctl(1, 0, 0, 0, 2'd0, 0, 3'd0));
    repeat (2) @(negedge clk);
    rd(2'd2, v);
    chk("R5 wraps to zero", v, 32'd0);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_wave(input bit inv);
    logic [31:0] ld = TOP - 9;
    logic [31:0] mt = TOP - 7;
    int per = 10;
    int hi = 3;
    int bad = 0;
    logic e;
    runWave(ld, mt, ctl(0, 1, 1, inv, 2'd3, 0, 3'd0), 32);
    for (int k = 1; k <= 32; k++) begin
      e = (k >= 2) && (((k - 2) % per) < hi);
      if (samp[k] !== (e ^ inv)) bad++;
    end
    if (inv) chk("R7 inverted waveform mismatches", bad, 0);
    else     chk("R6 waveform mismatches", bad, 0);
    chk(inv ? "R7 first active sample" : "R6 first active sample",
        {31'd0, samp[2]}, {31'd0, ~inv});
    wr(2'd3, ctl(0, 1, 1, inv, 2'd3, 0, 3'd0));
    chk(inv ? "R7 stopped level inverted" : "R2 stopped level",
        {31'd0, pwmOut}, {31'd0, inv});
  endtask

  task automatic t_trig;
    logic [31:0] ld = TOP - 9;
    logic [31:0] mt = TOP - 7;
    runWave(ld, mt, ctl(0, 1, 1, 0, 2'd1, 0, 3'd0), 12);
    chk("R8 overflow-only stays active past compare", {31'd0, samp[5]}, 32'd1);
    chk("R8 overflow-only ends at next overflow", {31'd0, samp[12]}, 32'd0);
    runWave(ld, mt, ctl(0, 1, 1, 0, 2'd2, 0, 3'd0), 12);
    chk("R8 compare-only ignores overflow", {31'd0, samp[2]}, 32'd0);
    chk("R8 compare-only before compare", {31'd0, samp[4]}, 32'd0);
    chk("R8 compare-only flips at compare", {31'd0, samp[5]}, 32'd1);
    runWave(ld, mt, ctl(0, 1, 0, 0, 2'd3, 0, 3'd0), 12);
    chk("R8 compare disabled keeps active", {31'd0, samp[5]}, 32'd1);
    chk("R8 compare disabled flips at overflow", {31'd0, samp[12]}, 32'd0);
    runWave(ld, mt, ctl(0, 1, 1, 0, 2'd0, 0, 3'd0), 12);
    chk("R8 no trigger no toggle a", {31'd0, samp[2]}, 32'd0);
    chk("R8 no trigger no toggle b", {31'd0, samp[5]}, 32'd0);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_psc;
    logic [31:0] v;
    wr(2'd2, 32'd100);
    wr(2'd3, ctl(1, 0, 0, 0, 2'd0, 1, 3'd1));
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R9 div4 before tick", v, 32'd100);
    @(negedge clk);
    rd(2'd2, v); chk("R9 div4 first tick", v, 32'd101);
    repeat (8) @(negedge clk);
    rd(2'd2, v); chk("R9 div4 after 12 clocks", v, 32'd103);
    wr(2'd3, 32'd0);
    wr(2'd2, 32'd100);
    wr(2'd3, ctl(1, 0, 0, 0, 2'd0, 1, 3'd0));
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk("R9 div2 after 10 clocks", v, 32'd105);
    wr(2'd3, 32'd0);
    wr(2'd2, 32'd100);
    wr(2'd3, ctl(1, 0, 0, 0, 2'd0, 1, 3'd7));
    repeat (255) @(negedge clk);
    rd(2'd2, v); chk("R9 div256 before tick", v, 32'd100);
    @(negedge clk);
    rd(2'd2, v); chk("R9 div256 first tick", v, 32'd101);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_odd;
    logic [31:0] v;
    int ones = 0;
    runWave(TOP - 2, TOP - 5, ctl(0, 1, 1, 0, 2'd3, 0, 3'd0), 12);
    rd(2'd2, v);
    chk("R10 compare below reload keeps cycling", v, TOP - 1);
    wr(2'd3, 32'd0);
    runWave(TOP - 3, TOP, ctl(0, 1, 1, 0, 2'd3, 0, 3'd0), 12);
    rd(2'd2, v);
    chk("R10 compare at top keeps cycling", v, TOP - 1);
    for (int k = 1; k <= 12; k++) if (samp[k]) ones++;
    chk("R10 coinciding events cancel", ones, 0);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    logic [31:0] cw = ctl(0, 1, 1, 1, 2'd2, 1, 3'd5);
    wr(2'd0, 32'hA5A5_0001);
    wr(2'd1, 32'h5A5A_0002);
    wr(2'd3, cw);
    rd(2'd0, v); chk("R11 reload readback", v, 32'hA5A5_0001);
    rd(2'd1, v); chk("R11 compare readback", v, 32'h5A5A_0002);
    rd(2'd3, v); chk("R11 control readback", v, cw);
    wr(2'd3, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_stopped;
    t_count;
    t_reload;
    t_wave(1'b0);
    t_wave(1'b1);
    t_trig;
    t_psc;
    t_odd;
    t_readback;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule